// File: doc/BRIEF.md
# Speculative Register Rename Table

This block tracks, for every architectural register, which in-flight instruction will produce its next value. Each producer is named by the window slot it occupies and by which of its two result outputs writes the register. When no producer is recorded, a lookup reports that the operand is already in the register file and can be read there.

The table keeps two full copies of the mapping. The correct-path copy is written by instructions renamed while the front end is on the right path. The speculative copy is written by instructions renamed after a mispredicted branch. A selector bitmap with one bit per register decides which copy a lookup returns. A speculative rename sets the bit for its register. Recovery only wipes the bitmap, in a single cycle, so the correct-path copy never has to be rebuilt.

At completion, a producer clears its entry, but only if it is still the recorded creator of that register. The producer's own speculation flag picks which copy is examined.

Top module: `speculative_rename_table`

## Requirements
- R1: After reset every lookup reports ready, with slot 0 and output index 0, and the selector bitmap is empty.
- R2: A lookup returns the speculative copy's entry when the register's selector bit is 1, and the correct copy's entry when it is 0. When that entry holds a producer, ready is 0 and the slot and output index of the producer are returned.
- R3: When the selected entry holds no producer, the lookup reports ready = 1 with slot and output index driven to 0.
- R4: A read port whose `rd_used` bit is 0 (operand not applicable) reports ready = 1 regardless of the table contents.
- R5: A rename-write with `wr_spec` = 0 stores the producer in the correct copy and leaves the selector alone. With `wr_spec` = 1 it stores the producer in the speculative copy and sets that register's selector bit. The new mapping is seen by lookups from the following cycle.
- R6: A writeback-clear empties an entry only when the entry holds a producer whose slot and output index both equal `wb_slot`/`wb_opn`. It examines only the copy chosen by `wb_spec` (0 = correct, 1 = speculative). In every other case both copies are left unchanged.
- R7: When a rename-write and a writeback-clear name the same register and the same copy in one cycle, the rename-write's entry is kept. If they name different copies, both take effect.
- R8: A `recover` pulse clears every selector bit in one cycle, and the correct copy is left as it was. Lookups afterwards return the correct copy. Outside of recovery, selector bits never drop.
- R9: When `recover` coincides with a speculative rename-write, the selector bitmap still ends up all zero.
- R10: Lookups in a cycle see the table as it stood before that cycle's clock edge. All read ports are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_used | input | NUM_RD | Per read port: 1 = operand present, 0 = not applicable |
| rd_reg | input | NUM_RD x REG_W | Per read port: architectural register looked up |
| rd_ready | output | NUM_RD | Per read port: operand is in the register file |
| rd_slot | output | NUM_RD x SLOT_W | Per read port: producer window slot (0 when ready) |
| rd_opn | output | NUM_RD | Per read port: producer output index (0 when ready) |
| wr_en | input | 1 | Rename-write valid |
| wr_reg | input | REG_W | Destination register being renamed |
| wr_slot | input | SLOT_W | Window slot of the new producer |
| wr_opn | input | 1 | Output index of the new producer |
| wr_spec | input | 1 | 1 = renamed on a mis-speculated path |
| wb_en | input | 1 | Writeback-clear valid |
| wb_reg | input | REG_W | Register written by the completing producer |
| wb_slot | input | SLOT_W | Window slot of the completing producer |
| wb_opn | input | 1 | Output index of the completing producer |
| wb_spec | input | 1 | Speculation flag of the completing producer |
| recover | input | 1 | Misprediction recovery pulse |

## Verification
The hardest state to reach is a register that holds live entries in both copies at once, with its selector bit set. A clear then arrives that matches only one copy, or a recovery must expose the older correct-path entry that was hidden behind the speculative one. The directed phase builds this state on purpose. It uses two interleaved register strides for correct-path and speculative renames, so that some registers carry both entries. It then aims clears with the exact, a near-miss and a wrong-copy tag at those registers. A pseudo-random phase follows, in which half the clears copy the tag from the bench's own model. This keeps matching clears frequent, interleaved with recoveries. Whole-table sweeps through both read ports compare every register against that model.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Which copy of the mapping an operation addresses.
  typedef enum logic {
    CP_CORR = 1'b0,
    CP_SPEC = 1'b1
  } rrt_copy_e;

  localparam int RRT_NUM_COPIES = 2;

  // Entry layout: {valid, slot[SLOT_W-1:0], output index}
  function automatic int rrt_ent_w(input int slot_w);
    return slot_w + 2;
  endfunction

endpackage

// File: rtl/rrt_copy.sv
module rrt_copy #(
  parameter int NUM_REGS = 32,
  parameter int SLOT_W   = 6,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int ENT_W   = rrt_pkg::rrt_ent_w(SLOT_W)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_hit,
  input  logic [REG_W-1:0]               wr_reg,
  input  logic [ENT_W-1:0]               wr_ent,
  input  logic                           clr_req,
  input  logic [REG_W-1:0]               clr_reg,
  input  logic [SLOT_W-1:0]              clr_slot,
  input  logic                           clr_opn,
  output logic [NUM_REGS-1:0][ENT_W-1:0] tbl
);

  localparam int VLD = ENT_W - 1;

  // Entry still names the completing producer.
  function automatic logic tag_hit(input logic [ENT_W-1:0] e,
                                   input logic [SLOT_W-1:0] s,
                                   input logic o);
    return e[VLD] && (e[VLD-1:1] == s) && (e[0] == o);
  endfunction

  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] clr_sel;
  logic                clr_fire;
  logic                wr_clr_same;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign wr_sel[g]  = wr_hit && (wr_reg == REG_W'(g));
    assign clr_sel[g] = clr_req && (clr_reg == REG_W'(g)) && tag_hit(tbl[g], clr_slot, clr_opn);
  end

  assign clr_fire    = |clr_sel;
  assign wr_clr_same = wr_hit && clr_req && (wr_reg == clr_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_sel[i])       tbl[i]      <= wr_ent;
        else if (clr_sel[i]) tbl[i][VLD] <= 1'b0;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> tbl[$past(wr_reg)] == $past(wr_ent)); // R5

  AST_CLEAR_MATCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire && !wr_clr_same |=> !tbl[$past(clr_reg)][VLD]); // R6

  AST_CLEAR_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !clr_fire && !wr_clr_same |=> tbl[$past(clr_reg)] == $past(tbl[clr_reg])); // R6

  AST_WRITE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_same |=> tbl[$past(wr_reg)][VLD]); // R7

endmodule

// File: rtl/rrt_selmap.sv
module rrt_selmap #(
  parameter int NUM_REGS = 32,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_req,
  input  logic [REG_W-1:0]    set_reg,
  input  logic                recover,
  output logic [NUM_REGS-1:0] sel
);

  function automatic logic [NUM_REGS-1:0] reg_bit(input logic [REG_W-1:0] r);
    return NUM_REGS'(1) << r;
  endfunction

  logic [NUM_REGS-1:0] set_mask;
  assign set_mask = set_req ? reg_bit(set_reg) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel <= '0;
    else if (recover) sel <= '0;
    else              sel <= sel | set_mask;
  end

  AST_RECOVER_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> sel == '0); // R8

  AST_RECOVER_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    recover && set_req |=> !sel[$past(set_reg)]); // R9

  AST_SPEC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req && !recover |=> sel[$past(set_reg)]); // R5

  AST_SEL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !recover |=> (sel & $past(sel)) == $past(sel)); // R8

endmodule

// File: rtl/rrt_rdport.sv
module rrt_rdport #(
  parameter int NUM_REGS = 32,
  parameter int SLOT_W   = 6,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int ENT_W   = rrt_pkg::rrt_ent_w(SLOT_W)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           used,
  input  logic [REG_W-1:0]               rd_reg,
  input  logic [NUM_REGS-1:0]            sel,
  input  logic [NUM_REGS-1:0][ENT_W-1:0] corr_tbl,
  input  logic [NUM_REGS-1:0][ENT_W-1:0] spec_tbl,
  output logic                           ready,
  output logic [SLOT_W-1:0]              slot,
  output logic                           opn
);

  localparam int VLD = ENT_W - 1;

  function automatic logic [ENT_W-1:0] pick(input logic use_spec,
                                            input logic [ENT_W-1:0] c,
                                            input logic [ENT_W-1:0] s);
    return use_spec ? s : c;
  endfunction

  logic [ENT_W-1:0] ent;
  assign ent   = pick(sel[rd_reg], corr_tbl[rd_reg], spec_tbl[rd_reg]);
  assign ready = !used || !ent[VLD];
  assign slot  = ready ? '0 : ent[VLD-1:1];
  assign opn   = ready ? 1'b0 : ent[0];

  AST_NA_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !used |-> ready); // R4

  AST_READY_ZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (slot == '0) && !opn); // R3

endmodule

// File: rtl/speculative_rename_table.sv
module speculative_rename_table #(
  parameter int NUM_REGS = 32,
  parameter int SLOT_W   = 6,
  parameter int NUM_RD   = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_RD-1:0]              rd_used,
  input  logic [NUM_RD-1:0][REG_W-1:0]   rd_reg,
  output logic [NUM_RD-1:0]              rd_ready,
  output logic [NUM_RD-1:0][SLOT_W-1:0]  rd_slot,
  output logic [NUM_RD-1:0]              rd_opn,
  input  logic                           wr_en,
  input  logic [REG_W-1:0]               wr_reg,
  input  logic [SLOT_W-1:0]              wr_slot,
  input  logic                           wr_opn,
  input  logic                           wr_spec,
  input  logic                           wb_en,
  input  logic [REG_W-1:0]               wb_reg,
  input  logic [SLOT_W-1:0]              wb_slot,
  input  logic                           wb_opn,
  input  logic                           wb_spec,
  input  logic                           recover
);

  import rrt_pkg::*;

  localparam int ENT_W = rrt_ent_w(SLOT_W);

  logic [RRT_NUM_COPIES-1:0][NUM_REGS-1:0][ENT_W-1:0] tbls;
  logic [NUM_REGS-1:0]                                sel;
  logic [ENT_W-1:0]                                   wr_ent;

  assign wr_ent = {1'b1, wr_slot, wr_opn};

  for (genvar c = 0; c < RRT_NUM_COPIES; c++) begin : g_copy
    localparam logic IS_SPEC = (c == int'(CP_SPEC));
    logic wr_hit_c;
    logic clr_req_c;
    assign wr_hit_c  = wr_en && (wr_spec == IS_SPEC);
    assign clr_req_c = wb_en && (wb_spec == IS_SPEC);

    rrt_copy #(.NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)) u_copy (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit_c),
      .wr_reg   (wr_reg),
      .wr_ent   (wr_ent),
      .clr_req  (clr_req_c),
      .clr_reg  (wb_reg),
      .clr_slot (wb_slot),
      .clr_opn  (wb_opn),
      .tbl      (tbls[c])
    );
  end

  rrt_selmap #(.NUM_REGS(NUM_REGS)) u_selmap (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (wr_en && wr_spec),
    .set_reg (wr_reg),
    .recover (recover),
    .sel     (sel)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rrt_rdport #(.NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .used     (rd_used[p]),
      .rd_reg   (rd_reg[p]),
      .sel      (sel),
      .corr_tbl (tbls[int'(CP_CORR)]),
      .spec_tbl (tbls[int'(CP_SPEC)]),
      .ready    (rd_ready[p]),
      .slot     (rd_slot[p]),
      .opn      (rd_opn[p])
    );
  end

  AST_RECOVER_KEEPS_CORRECT: assert property (@(posedge clk) disable iff (!rst_n)
    recover && !(wr_en && !wr_spec) && !(wb_en && !wb_spec)
      |=> $stable(tbls[int'(CP_CORR)])); // R8

  AST_SPEC_WRITE_SPARES_CORRECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_spec && !(wb_en && !wb_spec)
      |=> $stable(tbls[int'(CP_CORR)])); // R5

endmodule

// File: tb/speculative_rename_table_tb_top.sv
`timescale 1ns/1ps
module speculative_rename_table_tb_top;

  localparam int NR  = 32;
  localparam int SW  = 6;
  localparam int NRD = 2;
  localparam int RW  = 5;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NRD-1:0]          rd_used = '1;
  logic [NRD-1:0][RW-1:0]  rd_reg = '0;
  logic [NRD-1:0]          rd_ready;
  logic [NRD-1:0][SW-1:0]  rd_slot;
  logic [NRD-1:0]          rd_opn;
  logic                    wr_en = 0, wr_opn = 0, wr_spec = 0;
  logic [RW-1:0]           wr_reg = '0;
  logic [SW-1:0]           wr_slot = '0;
  logic                    wb_en = 0, wb_opn = 0, wb_spec = 0;
  logic [RW-1:0]           wb_reg = '0;
  logic [SW-1:0]           wb_slot = '0;
  logic                    recover = 0;

  speculative_rename_table #(.NUM_REGS(NR), .SLOT_W(SW), .NUM_RD(NRD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_used(rd_used), .rd_reg(rd_reg), .rd_ready(rd_ready), .rd_slot(rd_slot), .rd_opn(rd_opn),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_slot(wr_slot), .wr_opn(wr_opn), .wr_spec(wr_spec),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_slot(wb_slot), .wb_opn(wb_opn), .wb_spec(wb_spec),
    .recover(recover)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model: copy 0 = correct path, copy 1 = speculative
  logic          m_v [2][NR];
  logic [SW-1:0] m_s [2][NR];
  logic          m_o [2][NR];
  logic          m_sel [NR];

  task automatic model_reset();
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NR; r++) begin m_v[c][r] = 0; m_s[c][r] = '0; m_o[c][r] = 0; end
    for (int r = 0; r < NR; r++) m_sel[r] = 0;
  endtask

  // Effect of one clock edge with the given inputs, derived from R5-R9.
  task automatic model_edge(bit we, int wr, int ws, bit wo, bit wsp,
                            bit be, int br, int bs, bit bo, bit bsp, bit rec);
    int bc = bsp ? 1 : 0;
    int wc = wsp ? 1 : 0;
    if (be && m_v[bc][br] && (m_s[bc][br] == SW'(bs)) && (m_o[bc][br] == bo)) m_v[bc][br] = 0;
    if (we) begin m_v[wc][wr] = 1; m_s[wc][wr] = SW'(ws); m_o[wc][wr] = wo; end
    if (rec) begin
      for (int r = 0; r < NR; r++) m_sel[r] = 0;
    end else if (we && wsp) begin
      m_sel[wr] = 1;
    end
  endtask

  task automatic check_read(int p, bit used, int r, string req);
    logic          er, eo;
    logic [SW-1:0] es;
    int c = m_sel[r] ? 1 : 0;
    if (!used || !m_v[c][r]) begin er = 1; es = '0; eo = 0; end
    else begin er = 0; es = m_s[c][r]; eo = m_o[c][r]; end
    n_chk++;
    if (rd_ready[p] !== er || rd_slot[p] !== es || rd_opn[p] !== eo) begin
      n_fail++;
      $display("FAIL %s port %0d reg %0d: got ready=%0b slot=%0d opn=%0b, expected ready=%0b slot=%0d opn=%0b",
               req, p, r, rd_ready[p], rd_slot[p], rd_opn[p], er, es, eo);
    end
  endtask

  // Sweep every register on both ports (port 1 walks in reverse).
  task automatic sweep(string req, bit used = 1);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      rd_used = used ? '1 : '0;
      rd_reg[0] = RW'(r);
      rd_reg[1] = RW'(NR - 1 - r);
      #1;
      check_read(0, used, r, req);
      check_read(1, used, NR - 1 - r, req);
    end
    rd_used = '1;
  endtask

  task automatic step(bit we, int wr, int ws, bit wo, bit wsp,
                      bit be, int br, int bs, bit bo, bit bsp, bit rec);
    @(negedge clk);
    wr_en = we; wr_reg = RW'(wr); wr_slot = SW'(ws); wr_opn = wo; wr_spec = wsp;
    wb_en = be; wb_reg = RW'(br); wb_slot = SW'(bs); wb_opn = bo; wb_spec = bsp;
    recover = rec;
    @(posedge clk);
    model_edge(we, wr, ws, wo, wsp, be, br, bs, bo, bsp, rec);
    #1;
    wr_en = 0; wb_en = 0; recover = 0;
  endtask

  task automatic rename(int r, int s, bit o, bit sp);
    step(1, r, s, o, sp, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic clear(int r, int s, bit o, bit sp);
    step(0, 0, 0, 0, 0, 1, r, s, o, sp, 0);
  endtask

  function automatic logic [31:0] lfsr_next(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin : main
    logic [31:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: everything empty after reset
    sweep("R1");

    // R5 / R2: correct-path renames on a stride of 3
    for (int r = 0; r < NR; r += 3) rename(r, (r * 7) % 64, r[0], 0);
    sweep("R5");

    // R10: same-cycle lookup sees the old mapping; new one next cycle
    @(negedge clk);
    rd_reg[0] = RW'(4); rd_reg[1] = RW'(3);
    wr_en = 1; wr_reg = RW'(4); wr_slot = SW'(50); wr_opn = 1; wr_spec = 0;
    #1;
    check_read(0, 1, 4, "R10");
    check_read(1, 1, 3, "R10");
    @(posedge clk);
    model_edge(1, 4, 50, 1, 0, 0, 0, 0, 0, 0, 0);
    #1;
    wr_en = 0;
    check_read(0, 1, 4, "R10");

    // R5 / R2: speculative renames on a stride of 5 (overlaps at 0, 15, 30)
    for (int r = 0; r < NR; r += 5) rename(r, (r * 11 + 5) % 64, !r[0], 1);
    sweep("R2");

    // R4: operands not applicable are ready on every register
    sweep("R4", 0);

    // R6: exact match clears, near misses and wrong copy leave the entry
    clear(3, 21, 1, 0);            // exact tag, correct copy
    clear(6, 43, 0, 0);            // slot off by one
    clear(9, 63, 0, 0);            // output index wrong
    clear(12, 20, 0, 1);           // right tag, but speculative copy
    clear(15, (15 * 11 + 5) % 64, 0, 1); // exact tag in speculative copy
    clear(30, (30 * 7) % 64, 0, 0); // correct copy entry behind a set selector
    sweep("R6");
    sweep("R3");

    // R7: write and clear on the same register and copy, then on different copies
    step(1, 18, 33, 0, 0, 1, 18, (18 * 7) % 64, 0, 0, 0);
    step(1, 21, 44, 1, 1, 1, 21, (21 * 7) % 64, 1, 0, 0);
    sweep("R7");

    // R8: recovery exposes the correct copy again
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    sweep("R8");

    // R9: recovery together with a speculative rename leaves no selector set
    step(1, 7, 9, 1, 1, 0, 0, 0, 0, 0, 1);
    sweep("R9");

    // Mixed pseudo-random traffic, model-aimed clears keep matches frequent
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      int  wr, br, bs;
      bit  bsp, bo;
      lf = lfsr_next(lf); lf = lfsr_next(lf); lf = lfsr_next(lf);
      wr  = int'(lf[4:0]);
      br  = lf[20] ? wr : int'(lf[25:21]);
      bsp = lf[26];
      if (lf[27]) begin bs = int'(m_s[bsp][br]); bo = m_o[bsp][br]; end
      else begin bs = int'(lf[13:8]); bo = lf[14]; end
      step(lf[5], wr, int'(lf[11:6]), lf[12], lf[15],
           lf[16], br, bs, bo, bsp, (lf[31:28] == 4'hF));
      if (i % 100 == 99) sweep("R2");
    end
    sweep("R6");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule